// File: doc/BRIEF.md
# Shared Bus Command Decoder

This block watches a 40-bit command word on a bus that many boards share and decides, for its own board, whether the word is a controller access that must be answered. Each word is qualified by a strobe. The strobe, the word and the board's own address pass through synchronizer stages first. After one further settle cycle, the block checks four things: parity, the broadcast flag, the flag that picks the controller or the front-end chips, and the board address. It also checks that the instruction code is supported.

An accepted controller access produces a one-cycle request towards a register file, carrying the low register-address bits, the instruction code and the data field. A non-broadcast access also raises the acknowledge. Any register address is accepted. Two chip-select outputs steer external bus drivers: one for controller traffic and one for front-end-chip traffic.

For bus debugging, the block counts the strobes it receives and the acknowledges it sends. It also keeps the upper 20 bits of the last word it answered and of the last word it did not answer.

Top module: `pbus_addr_decoder`

## Requirements
- R1: An accepted controller word (bit 37 = 1) raises `reg_req_o` for exactly one cycle. In that same cycle it loads `reg_addr_o` from bits 31:25, `reg_instr_o` from bits 24:20 and `reg_data_o` from bits 19:0. These fields keep their values until the next accepted controller word.
- R2: Parity is even over bits 39:0. A word with odd parity raises `err_o` and produces no acknowledge and no chip select.
- R3: A word with bit 38 = 1 (broadcast) and bit 37 = 1 is performed whatever the board address is: `reg_req_o` and `cs_ctrl_o` rise. `ack_o` stays low.
- R4: When bit 38 = 0, bits 36:32 must equal `board_addr_i`. Otherwise the word causes no acknowledge, no error, no chip select and no request.
- R5: A controller word with good parity and a matching board address is acknowledged for every register address in bits 31:25.
- R6: If the instruction code in bits 24:20 is 24 or above, the word raises `err_o` and produces no acknowledge, no request and no `cs_ctrl_o`.
- R7: A valid front-end word (bit 37 = 0, good parity, addressed to this board) raises `cs_fe_o` and never `ack_o`. The two chip selects are never high together.
- R8: The outputs change at the fifth rising clock edge that samples the strobe high. The acknowledge, error and chip selects then hold while the strobe stays high. They clear at the third rising edge that samples the strobe low.
- R9: `strobe_cnt_o` adds one for each strobe rising edge accepted while the block is idle. `ack_cnt_o` adds one for each acknowledge raised. Both are 16 bits and wrap.
- R10: Bits 39:20 of each acknowledged word go to `last_ack_addr_o`. Bits 39:20 of each decoded word that is not acknowledged go to `last_nack_addr_o`.
- R11: While reset is high, and in the cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_word_i | input | 40 | Command word from the shared bus |
| strobe_i | input | 1 | Command strobe, asynchronous |
| board_addr_i | input | 5 | This board's address |
| ack_o | output | 1 | Acknowledge |
| err_o | output | 1 | Parity or instruction error |
| cs_ctrl_o | output | 1 | Chip select, controller transaction |
| cs_fe_o | output | 1 | Chip select, front-end transaction |
| reg_req_o | output | 1 | One-cycle request to the register file |
| reg_addr_o | output | 7 | Register address |
| reg_instr_o | output | 5 | Instruction code |
| reg_data_o | output | 20 | Data field |
| strobe_cnt_o | output | 16 | Strobes received |
| ack_cnt_o | output | 16 | Acknowledges sent |
| last_ack_addr_o | output | 20 | Upper bits of last acknowledged word |
| last_nack_addr_o | output | 20 | Upper bits of last unacknowledged word |

## Verification
Most faults in the sequencer show up on the acknowledge lines within a few cycles. A miscounted synchronizer or wait state moves the acknowledge off the fifth edge. A stuck state either clears the acknowledge while the strobe is still high or never clears it. A wrong field slice in the checker shows up as an acknowledge on a word for another board, or as a missing error on a bad-parity word, inside the same transaction. Faults in the debug counters and captures show only on their own outputs, one cycle after the decide edge. A reference model therefore compares every output on every cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  // Fixed layout of the 40-bit command word
  localparam int WORD_W  = 40;
  localparam int PAR_BIT = 39;
  localparam int BC_BIT  = 38;
  localparam int SEL_BIT = 37;
  localparam int HW_HI   = 36;
  localparam int REG_LO  = 25;
  localparam int INS_HI  = 24;
  localparam int INS_LO  = 20;
  localparam int DAT_HI  = 19;
  localparam int INS_W   = INS_HI - INS_LO + 1;
  localparam int DAT_W   = DAT_HI + 1;
  localparam int CAP_W   = WORD_W - INS_LO;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DECIDE,
    ST_HOLD
  } seq_state_t;

  typedef struct packed {
    logic bcast;
    logic par_bad;
    logic ins_bad;
    logic ctrl_hit;
    logic fe_hit;
  } verdict_t;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pbus_word_check.sv
module pbus_word_check
  import pbus_pkg::*;
#(
  parameter int HW_W        = 5,
  parameter int INSTR_LIMIT = 24
) (
  input  logic [WORD_W-1:0] word,
  input  logic [HW_W-1:0]   board_addr,
  output verdict_t          v
);
  localparam int HW_LO = HW_HI - HW_W + 1;

  logic par_bad, bcast, is_ctrl, addressed, code_bad;

  always_comb begin
    par_bad   = ^word;
    bcast     = word[BC_BIT];
    is_ctrl   = word[SEL_BIT];
    addressed = bcast || (word[HW_HI:HW_LO] == board_addr);
    code_bad  = ({27'd0, word[INS_HI:INS_LO]} >= INSTR_LIMIT);

    v.bcast    = bcast;
    v.par_bad  = par_bad;
    v.ins_bad  = !par_bad && is_ctrl && addressed && code_bad;
    v.ctrl_hit = !par_bad && is_ctrl && addressed && !code_bad;
    v.fe_hit   = !par_bad && !is_ctrl && addressed;
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int REG_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb_s,
  input  logic [WORD_W-1:0] word_s,
  input  verdict_t          v,
  output logic              ack_o,
  output logic              err_o,
  output logic              cs_ctrl_o,
  output logic              cs_fe_o,
  output logic              req_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic [INS_W-1:0]  reg_instr_o,
  output logic [DAT_W-1:0]  reg_data_o,
  output logic              rise_evt,
  output logic              decide_evt,
  output logic              decide_ack
);
  seq_state_t st;
  logic       strb_d;

  assign rise_evt   = (st == ST_IDLE) && strb_s && !strb_d;
  assign decide_evt = (st == ST_DECIDE);
  assign decide_ack = decide_evt && v.ctrl_hit && !v.bcast;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      strb_d      <= 1'b0;
      ack_o       <= 1'b0;
      err_o       <= 1'b0;
      cs_ctrl_o   <= 1'b0;
      cs_fe_o     <= 1'b0;
      req_o       <= 1'b0;
      reg_addr_o  <= '0;
      reg_instr_o <= '0;
      reg_data_o  <= '0;
    end else begin
      strb_d <= strb_s;
      req_o  <= 1'b0;
      case (st)
        ST_IDLE:   if (rise_evt) st <= ST_WAIT;
        ST_WAIT:   st <= ST_DECIDE;
        ST_DECIDE: begin
          ack_o     <= v.ctrl_hit && !v.bcast;
          err_o     <= v.par_bad || v.ins_bad;
          cs_ctrl_o <= v.ctrl_hit;
          cs_fe_o   <= v.fe_hit;
          req_o     <= v.ctrl_hit;
          if (v.ctrl_hit) begin
            reg_addr_o  <= word_s[REG_LO+REG_W-1:REG_LO];
            reg_instr_o <= word_s[INS_HI:INS_LO];
            reg_data_o  <= word_s[DAT_HI:0];
          end
          st <= ST_HOLD;
        end
        default: begin
          if (!strb_s) begin
            ack_o     <= 1'b0;
            err_o     <= 1'b0;
            cs_ctrl_o <= 1'b0;
            cs_fe_o   <= 1'b0;
            st        <= ST_IDLE;
          end
        end
      endcase
    end
  end

  p_req_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  p_ack_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_o && strb_s) |=> ack_o);
  p_ack_after_decide_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(decide_evt));
endmodule

// File: rtl/pbus_dbg.sv
module pbus_dbg
  import pbus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_s,
  input  logic              rise_evt,
  input  logic              decide_evt,
  input  logic              decide_ack,
  output logic [CNT_W-1:0]  strobe_cnt_o,
  output logic [CNT_W-1:0]  ack_cnt_o,
  output logic [CAP_W-1:0]  last_ack_o,
  output logic [CAP_W-1:0]  last_nack_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_cnt_o <= '0;
      ack_cnt_o    <= '0;
      last_ack_o   <= '0;
      last_nack_o  <= '0;
    end else begin
      if (rise_evt) strobe_cnt_o <= strobe_cnt_o + 1'b1;
      if (decide_ack) begin
        ack_cnt_o  <= ack_cnt_o + 1'b1;
        last_ack_o <= word_s[WORD_W-1:INS_LO];
      end else if (decide_evt) begin
        last_nack_o <= word_s[WORD_W-1:INS_LO];
      end
    end
  end

  p_ack_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    decide_ack |=> (ack_cnt_o == $past(ack_cnt_o) + 1'b1));
  p_strobe_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> (strobe_cnt_o == $past(strobe_cnt_o) + 1'b1));
  p_nack_keeps_ack_r10: assert property (@(posedge clk) disable iff (rst)
    !decide_ack |=> $stable(last_ack_o));
endmodule

// File: rtl/pbus_addr_decoder.sv
module pbus_addr_decoder
  import pbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HW_W        = 5,
  parameter int REG_W       = 7,
  parameter int CNT_W       = 16,
  parameter int INSTR_LIMIT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [39:0]       bus_word_i,
  input  logic              strobe_i,
  input  logic [HW_W-1:0]   board_addr_i,
  output logic              ack_o,
  output logic              err_o,
  output logic              cs_ctrl_o,
  output logic              cs_fe_o,
  output logic              reg_req_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic [4:0]        reg_instr_o,
  output logic [19:0]       reg_data_o,
  output logic [CNT_W-1:0]  strobe_cnt_o,
  output logic [CNT_W-1:0]  ack_cnt_o,
  output logic [19:0]       last_ack_addr_o,
  output logic [19:0]       last_nack_addr_o
);
  logic              strb_s;
  logic [WORD_W-1:0] word_s;
  logic [HW_W-1:0]   board_s;
  verdict_t          v;
  logic              rise_evt, decide_evt, decide_ack;

  pbus_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_strb (
    .clk(clk), .rst(rst), .d(strobe_i), .q(strb_s));
  pbus_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync_word (
    .clk(clk), .rst(rst), .d(bus_word_i), .q(word_s));
  pbus_sync #(.W(HW_W), .STAGES(SYNC_STAGES)) u_sync_board (
    .clk(clk), .rst(rst), .d(board_addr_i), .q(board_s));

  pbus_word_check #(.HW_W(HW_W), .INSTR_LIMIT(INSTR_LIMIT)) u_check (
    .word(word_s), .board_addr(board_s), .v(v));

  pbus_seq #(.REG_W(REG_W)) u_seq (
    .clk(clk), .rst(rst), .strb_s(strb_s), .word_s(word_s), .v(v),
    .ack_o(ack_o), .err_o(err_o), .cs_ctrl_o(cs_ctrl_o), .cs_fe_o(cs_fe_o),
    .req_o(reg_req_o), .reg_addr_o(reg_addr_o), .reg_instr_o(reg_instr_o),
    .reg_data_o(reg_data_o), .rise_evt(rise_evt), .decide_evt(decide_evt),
    .decide_ack(decide_ack));

  pbus_dbg #(.CNT_W(CNT_W)) u_dbg (
    .clk(clk), .rst(rst), .word_s(word_s), .rise_evt(rise_evt),
    .decide_evt(decide_evt), .decide_ack(decide_ack),
    .strobe_cnt_o(strobe_cnt_o), .ack_cnt_o(ack_cnt_o),
    .last_ack_o(last_ack_addr_o), .last_nack_o(last_nack_addr_o));

  p_ack_not_err_r2: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !err_o);
  p_cs_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(cs_ctrl_o && cs_fe_o));
  p_ack_has_cs_r5: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> cs_ctrl_o);
  p_fe_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    cs_fe_o |-> !ack_o);
endmodule

// File: tb/pbus_addr_decoder_tb.sv
`timescale 1ns/1ps
module pbus_addr_decoder_tb_top;
  localparam logic [4:0] BOARD = 5'h0B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] bus_word = '0;
  logic        strobe = 1'b0;
  logic [4:0]  board_addr = BOARD;
  logic        ack_o, err_o, cs_ctrl_o, cs_fe_o, reg_req_o;
  logic [6:0]  reg_addr_o;
  logic [4:0]  reg_instr_o;
  logic [19:0] reg_data_o;
  logic [15:0] strobe_cnt_o, ack_cnt_o;
  logic [19:0] last_ack_addr_o, last_nack_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pbus_addr_decoder dut_i (
    .clk(clk), .rst(rst), .bus_word_i(bus_word), .strobe_i(strobe),
    .board_addr_i(board_addr), .ack_o(ack_o), .err_o(err_o),
    .cs_ctrl_o(cs_ctrl_o), .cs_fe_o(cs_fe_o), .reg_req_o(reg_req_o),
    .reg_addr_o(reg_addr_o), .reg_instr_o(reg_instr_o),
    .reg_data_o(reg_data_o), .strobe_cnt_o(strobe_cnt_o),
    .ack_cnt_o(ack_cnt_o), .last_ack_addr_o(last_ack_addr_o),
    .last_nack_addr_o(last_nack_addr_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [39:0] mk(input bit bc, input bit ctrl, input logic [4:0] hw,
                                     input logic [6:0] ra, input logic [4:0] ins,
                                     input logic [19:0] dat, input bit bad_par);
    logic [39:0] w;
    w = {1'b0, bc, ctrl, hw, ra, ins, dat};
    w[39] = (^w[38:0]) ^ bad_par;
    return w;
  endfunction

  // Reference model: inputs seen two clocks late, one settle cycle, then decision
  logic [45:0] q[$];
  int          ph = 0;
  logic        prev_s = 0;
  logic        m_ack = 0, m_err = 0, m_csc = 0, m_csf = 0, m_req = 0;
  logic [6:0]  m_ra = '0;
  logic [4:0]  m_ins = '0;
  logic [19:0] m_dat = '0, m_lack = '0, m_lnack = '0;
  logic [15:0] m_scnt = '0, m_acnt = '0;

  always @(posedge clk) begin
    logic [45:0] view;
    logic        vs;
    logic [39:0] w;
    logic [4:0]  b;
    bit par_ok, addressed, ins_ok, ctrl_ok, fe_ok, acked;
    if (rst) begin
      q.delete();
      ph = 0; prev_s = 0;
      m_ack = 0; m_err = 0; m_csc = 0; m_csf = 0; m_req = 0;
      m_ra = '0; m_ins = '0; m_dat = '0; m_lack = '0; m_lnack = '0;
      m_scnt = '0; m_acnt = '0;
    end else begin
      q.push_back({board_addr, bus_word, strobe});
      if (q.size() > 3) void'(q.pop_front());
      view = (q.size() == 3) ? q[0] : '0;
      vs = view[0];
      w  = view[40:1];
      b  = view[45:41];
      m_req = 0;
      if (ph == 0) begin
        if (vs && !prev_s) begin ph = 1; m_scnt = m_scnt + 1; end
      end else if (ph == 1) begin
        ph = 2;
      end else if (ph == 2) begin
        par_ok    = ((^w) == 1'b0);
        addressed = w[38] || (w[36:32] == b);
        ins_ok    = (w[24:20] < 5'd24);
        ctrl_ok   = par_ok && w[37] && addressed && ins_ok;
        fe_ok     = par_ok && !w[37] && addressed;
        acked     = ctrl_ok && !w[38];
        m_ack = acked;
        m_err = !par_ok || (w[37] && addressed && !ins_ok);
        m_csc = ctrl_ok;
        m_csf = fe_ok;
        m_req = ctrl_ok;
        if (ctrl_ok) begin m_ra = w[31:25]; m_ins = w[24:20]; m_dat = w[19:0]; end
        if (acked) begin m_acnt = m_acnt + 1; m_lack = w[39:20]; end
        else m_lnack = w[39:20];
        ph = 3;
      end else begin
        if (!vs) begin m_ack = 0; m_err = 0; m_csc = 0; m_csf = 0; ph = 0; end
      end
      prev_s = vs;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R5 ack", ack_o, m_ack);
      chk("R2 err", err_o, m_err);
      chk("R3 cs_ctrl", cs_ctrl_o, m_csc);
      chk("R7 cs_fe", cs_fe_o, m_csf);
      chk("R1 req", reg_req_o, m_req);
      chk("R1 fields", {reg_addr_o, reg_instr_o, reg_data_o}, {m_ra, m_ins, m_dat});
      chk("R9 strobe count", strobe_cnt_o, m_scnt);
      chk("R9 ack count", ack_cnt_o, m_acnt);
      chk("R10 last ack", last_ack_addr_o, m_lack);
      chk("R10 last nack", last_nack_addr_o, m_lnack);
    end
  end

  task automatic send(input logic [39:0] w, input int hold);
    @(negedge clk);
    bus_word = w;
    strobe = 1'b1;
    repeat (hold) @(negedge clk);
    strobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Send a word and track the decision window; returns flags seen while held
  task automatic send_obs(input logic [39:0] w, output bit saw_ack, output bit saw_err,
                          output bit saw_cs, output bit saw_req);
    saw_ack = 0; saw_err = 0; saw_cs = 0; saw_req = 0;
    @(negedge clk);
    bus_word = w;
    strobe = 1'b1;
    repeat (8) begin
      @(negedge clk);
      saw_ack |= ack_o; saw_err |= err_o; saw_cs |= (cs_ctrl_o | cs_fe_o); saw_req |= reg_req_o;
    end
    strobe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit a, e, c, r;
    logic [15:0] acnt0;
    repeat (4) @(negedge clk);
    // R11: outputs zero during reset
    chk("R11 reset outs", {ack_o, err_o, cs_ctrl_o, cs_fe_o, reg_req_o, strobe_cnt_o, ack_cnt_o,
                           last_ack_addr_o, last_nack_addr_o}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after reset", {ack_o, err_o, cs_ctrl_o, cs_fe_o, reg_req_o}, '0);

    // R8: acknowledge at fifth edge, clear at third low edge
    @(negedge clk);
    bus_word = mk(0, 1, BOARD, 7'h05, 5'd3, 20'hABCDE, 0);
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 no ack before fifth edge", ack_o, 1'b0);
    @(negedge clk);
    chk("R8 ack at fifth edge", ack_o, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 ack held with strobe", ack_o, 1'b1);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 ack still high two edges after drop", ack_o, 1'b1);
    @(negedge clk);
    chk("R8 ack clears third edge after drop", ack_o, 1'b0);
    repeat (4) @(negedge clk);

    // R5: any register address acknowledged, including extremes
    send_obs(mk(0, 1, BOARD, 7'h7F, 5'd0, 20'h00001, 0), a, e, c, r);
    chk("R5 ack reg 7F", a, 1'b1);
    send_obs(mk(0, 1, BOARD, 7'h00, 5'd23, 20'hFFFFF, 0), a, e, c, r);
    chk("R5 ack reg 00 code 23", a, 1'b1);

    // R2: parity error
    send_obs(mk(0, 1, BOARD, 7'h11, 5'd2, 20'h12345, 1), a, e, c, r);
    chk("R2 parity no ack", a, 1'b0);
    chk("R2 parity err", e, 1'b1);
    chk("R2 parity no cs", c, 1'b0);

    // R3: broadcast to another board address
    send_obs(mk(1, 1, 5'h1F, 7'h22, 5'd4, 20'h0F0F0, 0), a, e, c, r);
    chk("R3 bcast no ack", a, 1'b0);
    chk("R3 bcast req", r, 1'b1);
    chk("R3 bcast cs", c, 1'b1);

    // R4: address mismatch leaves everything quiet, counters only see the strobe
    acnt0 = ack_cnt_o;
    send_obs(mk(0, 1, 5'h0C, 7'h33, 5'd1, 20'h55555, 0), a, e, c, r);
    chk("R4 mismatch no ack/err/cs/req", {a, e, c, r}, 4'b0000);
    chk("R4 ack count unchanged", ack_cnt_o, acnt0);

    // R6: unsupported instruction code
    send_obs(mk(0, 1, BOARD, 7'h44, 5'd24, 20'h00077, 0), a, e, c, r);
    chk("R6 bad code err", e, 1'b1);
    chk("R6 bad code no ack/req", {a, r}, 2'b00);
    send_obs(mk(0, 1, BOARD, 7'h44, 5'd31, 20'h00077, 0), a, e, c, r);
    chk("R6 code 31 err", e, 1'b1);

    // R7: front-end word
    send_obs(mk(0, 0, BOARD, 7'h12, 5'd9, 20'h00ABC, 0), a, e, c, r);
    chk("R7 fe no ack", a, 1'b0);
    chk("R7 fe cs", c, 1'b1);

    // Mixed patterns: R1..R10 compared each cycle by the model
    for (int i = 0; i < 80; i++) begin
      logic [4:0] hw;
      hw = ($urandom % 4 == 0) ? 5'($urandom) : BOARD;
      send(mk(($urandom % 6) == 0, ($urandom % 3) != 0, hw, 7'($urandom), 5'($urandom),
              20'($urandom), ($urandom % 8) == 0), 1 + ($urandom % 8));
    end

    // R9: board address change is followed after synchronizing
    board_addr = 5'h02;
    repeat (4) @(negedge clk);
    send_obs(mk(0, 1, 5'h02, 7'h01, 5'd5, 20'h00002, 0), a, e, c, r);
    chk("R4 new board address acked", a, 1'b1);
    chk("R9 final ack count", ack_cnt_o, m_acnt);

    finished = 1;
    summary();
    $finish;
  end
endmodule